// File: doc/BRIEF.md
# Battery Protection Alert and Fault Evaluator

This block watches up to sixteen battery protection slots at once. For each slot, an external comparator stage supplies two flags. One says the sampled parameter is past its programmed limit; the other says it has come back inside that limit by the recovery margin. The evaluator turns these flags into a two-stage result. The slot first shows an early warning, called the alert. If the condition persists through a programmed number of sample ticks, the alert is replaced by a latched fault. That fault holds until a tick arrives on which the recovery flag is set.

Evaluation advances only on a sample tick, so the bench or the surrounding system decides the sampling rate. Each slot has its own delay count and its own enable bit. The results leave the block as two alert bytes and two fault bytes with a fixed bit layout, so a register front end can return them unchanged. The slot at second-byte bit 2 is reserved and is not built. The two lowest slots of the first byte report faults only and never show an alert.

Top module: `prot_eval_bank`

## Requirements
- R1: On a tick where an enabled slot with a nonzero delay is tripped and not faulted, its alert bit reads 1 after that clock edge.
- R2: A slot whose delay is D raises its fault on the D+1-th consecutive tripped tick. Its alert bit drops on the same edge. Alert and fault are never both 1.
- R3: A fault stays set until a tick with the recovery flag high; that tick clears it. A trip seen while the fault is held does not raise the alert.
- R4: The bit layout is fixed. First bytes: bit 7 cell overvoltage, 6 cell undervoltage, 5 discharge short circuit, 4 discharge overcurrent 1, 3 discharge overcurrent 2, 2 charge overcurrent; in the fault byte only, 1 current latch and 0 regulator. Second bytes: 7 discharge overtemperature, 6 charge overtemperature, 5 discharge undertemperature, 4 charge undertemperature, 3 internal overtemperature, 2 reserved (reads 0), 1 reference diagnostic, 0 ground diagnostic.
- R5: If a tick arrives with the trip flag low before the fault is reached, the alert clears and the delay count restarts from zero.
- R6: Without a tick, alert, fault and delay count of every slot hold their values.
- R7: With a delay of 0, the first tripped tick sets the fault directly and the alert never rises.
- R8: A disabled slot never raises alert or fault. Clearing its enable bit zeroes its output bits in the same cycle and clears its stored state, so re-enabling it shows no fault.
- R9: After reset, all four output bytes read 0. First-byte alert bits 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Sample tick; evaluation steps only when high |
| trip_i | input | 16 | Beyond-threshold flags; bits 7:0 first byte, 15:8 second byte |
| recov_i | input | 16 | Recovery-margin-met flags, same indexing |
| en_a_i | input | 8 | Enable bits for first-byte slots |
| en_b_i | input | 8 | Enable bits for second-byte slots |
| dly_i | input | 128 | Delay counts, 8 bits per slot, slot i at bits [8i+7:8i] |
| alert_a_o | output | 8 | First alert byte |
| alert_b_o | output | 8 | Second alert byte |
| fault_a_o | output | 8 | First fault byte |
| fault_b_o | output | 8 | Second fault byte |

## Verification
The in-RTL properties check on every cycle that alert and fault are mutually exclusive, that neither rises without a tripped tick, that a held fault survives every cycle lacking a recovery tick, that slot state freezes between ticks, and that a disabled slot is emptied. Only the bench scenarios show the exact count of ticks before escalation, the delay-zero shortcut, the restart after an interrupted trip, and the byte layout including the hidden and reserved positions.

// File: rtl/prot_eval_pkg.sv
package prot_eval_pkg;
  localparam int unsigned NSLOT = 16;
  // bit i of these masks is slot i; slots 7:0 first byte, 15:8 second byte
  localparam logic [NSLOT-1:0] SLOT_BUILT = 16'hFBFF;
  localparam logic [NSLOT-1:0] ALERT_SHOWN = 16'hFBFC;
endpackage

// File: rtl/prot_slot.sv
module prot_slot #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          trip_i,
  input  logic          recov_i,
  input  logic [DW-1:0] dly_i,
  output logic          alert_o,
  output logic          fault_o
);
  logic          alert_q, alert_d;
  logic          fault_q, fault_d;
  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    alert_d = alert_q;
    fault_d = fault_q;
    cnt_d   = cnt_q;
    if (!en_i) begin
      alert_d = 1'b0;
      fault_d = 1'b0;
      cnt_d   = '0;
    end else if (tick_i) begin
      if (fault_q) begin
        alert_d = 1'b0;
        cnt_d   = '0;
        if (recov_i) fault_d = 1'b0;
      end else if (trip_i) begin
        if (cnt_q >= dly_i) begin
          fault_d = 1'b1;
          alert_d = 1'b0;
          cnt_d   = '0;
        end else begin
          alert_d = 1'b1;
          cnt_d   = cnt_q + 1'b1;
        end
      end else begin
        alert_d = 1'b0;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alert_q <= 1'b0;
      fault_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      alert_q <= alert_d;
      fault_q <= fault_d;
      cnt_q   <= cnt_d;
    end
  end

  assign alert_o = alert_q & en_i;
  assign fault_o = fault_q & en_i;

  AST_NEVER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alert_q && fault_q)); // R2
  AST_FAULT_NEEDS_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(trip_i && tick_i && en_i)); // R2
  AST_ALERT_NEEDS_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_q) |-> $past(trip_i && tick_i && en_i && !fault_q)); // R1
  AST_FAULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && en_i && !(tick_i && recov_i)) |=> fault_q); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> ($stable(alert_q) && $stable(fault_q) && $stable(cnt_q))); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!alert_q && !fault_q && cnt_q == '0)); // R8
endmodule

// File: rtl/prot_pack.sv
module prot_pack
  import prot_eval_pkg::*;
(
  input  logic [NSLOT-1:0] alert_v_i,
  input  logic [NSLOT-1:0] fault_v_i,
  output logic [7:0]       alert_a_o,
  output logic [7:0]       alert_b_o,
  output logic [7:0]       fault_a_o,
  output logic [7:0]       fault_b_o
);
  logic [NSLOT-1:0] alert_m, fault_m;

  always_comb begin
    alert_m = alert_v_i & ALERT_SHOWN;
    fault_m = fault_v_i & SLOT_BUILT;
  end

  assign alert_a_o = alert_m[7:0];
  assign alert_b_o = alert_m[15:8];
  assign fault_a_o = fault_m[7:0];
  assign fault_b_o = fault_m[15:8];
endmodule

// File: rtl/prot_eval_bank.sv
module prot_eval_bank
  import prot_eval_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NSLOT-1:0]    trip_i,
  input  logic [NSLOT-1:0]    recov_i,
  input  logic [7:0]          en_a_i,
  input  logic [7:0]          en_b_i,
  input  logic [NSLOT*DW-1:0] dly_i,
  output logic [7:0]          alert_a_o,
  output logic [7:0]          alert_b_o,
  output logic [7:0]          fault_a_o,
  output logic [7:0]          fault_b_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [NSLOT-1:0] en_v, alert_v, fault_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];
  assign en_v  = {en_b_i, en_a_i};

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (SLOT_BUILT[i]) begin : g_built
      prot_slot #(.DW(DW)) i_slot (
        .clk_i   (clk_i),
        .rst_ni  (rst_n),
        .tick_i  (tick_i),
        .en_i    (en_v[i]),
        .trip_i  (trip_i[i]),
        .recov_i (recov_i[i]),
        .dly_i   (dly_i[i*DW +: DW]),
        .alert_o (alert_v[i]),
        .fault_o (fault_v[i])
      );
    end else begin : g_rsvd
      assign alert_v[i] = 1'b0;
      assign fault_v[i] = 1'b0;
    end
  end

  prot_pack i_pack (
    .alert_v_i (alert_v),
    .fault_v_i (fault_v),
    .alert_a_o (alert_a_o),
    .alert_b_o (alert_b_o),
    .fault_a_o (fault_a_o),
    .fault_b_o (fault_b_o)
  );
endmodule

// File: tb/test_prot_eval_bank.sv
module test_prot_eval_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick;
  logic [15:0]   trip, recov;
  logic [7:0]    en_a, en_b;
  logic [16*DW-1:0] dly;
  logic [7:0]    alert_a, alert_b, fault_a, fault_b;
  int            errors = 0;
  int            checks = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_eval_bank #(.DW(DW)) i_prot_eval_bank (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .trip_i(trip), .recov_i(recov),
    .en_a_i(en_a), .en_b_i(en_b), .dly_i(dly),
    .alert_a_o(alert_a), .alert_b_o(alert_b), .fault_a_o(fault_a), .fault_b_o(fault_b)
  );

  // {tick, trip, recov, expected alert, expected fault} for first-byte bit 7, delay 2
  localparam logic [4:0] VEC [13] = '{
    5'b10000, // idle tick
    5'b11010, // R1 first tripped tick raises alert
    5'b01010, // R6 no tick: hold
    5'b11010, // second tripped tick, still alert
    5'b10000, // R5 trip lost: alert clears, count restarts
    5'b11010, // restart tick 1
    5'b11010, // tick 2
    5'b11001, // R2 tick 3 = delay+1: fault, alert drops
    5'b11001, // R3 trip during fault: no alert
    5'b10001, // R3 no recovery flag: held
    5'b00101, // R6 recovery without tick: held
    5'b10100, // R3 recovery tick clears
    5'b11010  // alert again after recovery
  };

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(logic tk, logic [15:0] tr, logic [15:0] rc);
    tick = tk; trip = tr; recov = rc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; trip = '0; recov = '0;
    en_a = '0; en_b = '0; dly = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset alert_a", alert_a, 8'h00);
    chk("R9 reset alert_b", alert_b, 8'h00);
    chk("R9 reset fault_a", fault_a, 8'h00);
    chk("R9 reset fault_b", fault_b, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk on slot 7
    en_a = 8'h80; dly[7*DW +: DW] = 8'd2;
    for (int k = 0; k < 13; k++) begin
      step(VEC[k][4], {8'h00, VEC[k][3], 7'h00}, {8'h00, VEC[k][2], 7'h00});
      chk($sformatf("R1/R2/R3/R5/R6 vec%0d alert", k), {7'h0, alert_a[7]}, {7'h0, VEC[k][1]});
      chk($sformatf("R1/R2/R3/R5/R6 vec%0d fault", k), {7'h0, fault_a[7]}, {7'h0, VEC[k][0]});
    end

    // R8: drive to fault, then drop enable
    step(1'b1, 16'h0080, 16'h0000);
    step(1'b1, 16'h0080, 16'h0000);
    chk("R8 fault before disable", fault_a, 8'h80);
    en_a = 8'h00;
    #1;
    chk("R8 disable clears same cycle", fault_a, 8'h00);
    step(1'b0, 16'h0080, 16'h0000);
    en_a = 8'h80;
    #1;
    chk("R8 re-enable shows no fault", fault_a, 8'h00);
    chk("R8 re-enable shows no alert", alert_a, 8'h00);
    en_a = 8'h00;
    for (int k = 0; k < 5; k++) step(1'b1, 16'hFFFF, 16'h0000);
    chk("R8 disabled never alerts", alert_a, 8'h00);
    chk("R8 disabled never faults", fault_a, 8'h00);

    // R7: delay zero on ground diagnostic slot (second byte bit 0)
    en_b = 8'h01; dly[8*DW +: DW] = 8'd0;
    step(1'b1, 16'h0100, 16'h0000);
    chk("R7 delay zero fault", fault_b, 8'h01);
    chk("R7 delay zero no alert", alert_b, 8'h00);
    step(1'b1, 16'h0000, 16'h0100);
    chk("R7 recovered", fault_b, 8'h00);

    // R4/R9: full layout, all delays 1
    en_a = 8'hFF; en_b = 8'hFF;
    for (int s = 0; s < 16; s++) dly[s*DW +: DW] = 8'd1;
    step(1'b1, 16'hFFFF, 16'h0000);
    chk("R4 R9 alert_a layout", alert_a, 8'hFC);
    chk("R4 alert_b layout", alert_b, 8'hFB);
    chk("R4 no fault yet a", fault_a, 8'h00);
    step(1'b1, 16'hFFFF, 16'h0000);
    chk("R4 fault_a layout", fault_a, 8'hFF);
    chk("R4 fault_b layout", fault_b, 8'hFB);
    chk("R2 alerts dropped a", alert_a, 8'h00);
    chk("R2 alerts dropped b", alert_b, 8'h00);
    step(1'b1, 16'h0000, 16'hFFFF);
    chk("R3 bulk recovery a", fault_a, 8'h00);
    chk("R3 bulk recovery b", fault_b, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule